// File: doc/BRIEF.md
# Command Sequence Decoder with Identification Mode

This block sits on the device side of a byte-wide non-volatile memory. It watches each write strobe and recognises commands only when they arrive as exact, ordered address/data pairs. A command opens with two unlock bytes, AAH written to 5555H and then 55H written to 2AAAH. A third byte written to 5555H then selects a command, or leads into a longer six-byte form. The block keeps the write-protection state. It decides which data writes may reach the storage array, and it raises a one-cycle pulse for each write it lets through. It also raises a one-cycle pulse when a whole-array erase is requested.

While identification mode is active, the read path is switched away from the array. It then returns a manufacturer code or a device code instead. An exit command leaves identification mode only after a settling pause, and writes during that pause are ignored. The storage array itself is not part of this block.

Top module: `cmdseq_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `id_mode` is 0, `prot_on` equals PROT_AT_RESET (default 0), and `arr_we` and `erase_pulse` are 0.
- R2: The three-byte sequence AAH@5555H, 55H@2AAAH, A0H@5555H sets `prot_on` and opens a load window. Each later write in that window raises `arr_we` for exactly the cycle after its strobe, with `arr_addr`/`arr_data` equal to that write's address and data.
- R3: The load window closes after PAGE_BYTES accepted writes, or once LOAD_WIN consecutive cycles pass without a write. After it closes, a write while protected produces no `arr_we`.
- R4: A write outside any sequence or window is passed to the array (`arr_we` the cycle after the strobe) only when `prot_on` is 0 and `id_mode` is 0. Otherwise it is discarded.
- R5: The six-byte sequence AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, 20H@5555H clears `prot_on` on the cycle after the last strobe.
- R6: The same six-byte prefix ending in 10H@5555H raises `erase_pulse` for exactly one cycle, the cycle after the last strobe, and writes nothing to the array.
- R7: Identification mode (`id_mode`=1, from the cycle after the last strobe) is entered either by a three-byte sequence ending in 90H@5555H or by a six-byte sequence ending in 60H@5555H.
- R8: `id_rd_sel` equals `id_mode`. While `id_mode` is 1, `id_rd_data` is BFH when `rd_addr` bit 0 is 0, and the device code when it is 1 (07H for DEV_VARIANT 0, 08H otherwise); the output is combinational. It is 00H when `id_mode` is 0.
- R9: A three-byte sequence ending in F0H@5555H starts a pause of EXIT_PAUSE cycles. `id_mode` holds its value through the pause and drops to 0 at its end, and writes during the pause have no effect.
- R10: A write that does not match the expected next step returns the decoder to idle. Neither that write nor the partial sequence causes any output change.
- R11: Only address bits 14..0 take part in command matching, so, for example, D555H matches 5555H.
- R12: While `id_mode` is 1, plain writes are discarded, while command sequences are still recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write step strobe |
| wr_addr | input | ADDR_W | Address of the write step |
| wr_data | input | DATA_W | Data of the write step |
| rd_addr | input | ADDR_W | Read address used by the identification mux |
| id_mode | output | 1 | Identification mode active |
| prot_on | output | 1 | Write protection enabled |
| id_rd_sel | output | 1 | Read mux selects identification data |
| id_rd_data | output | DATA_W | Identification byte for the current read address |
| arr_we | output | 1 | One-cycle array write enable |
| arr_addr | output | ADDR_W | Address of the accepted array write |
| arr_data | output | DATA_W | Data of the accepted array write |
| erase_pulse | output | 1 | One-cycle whole-array erase request |

## Verification
The assertions take for granted that each write step is a single-cycle `wr_stb` pulse, with address and data stable across the sampling edge, and that the data width is one byte. They also take for granted that `rd_addr` changes only between edges. The stimulus meets these assumptions by driving every input on the falling edge. It follows each strobe with at least one quiet cycle. This also keeps gaps inside a load window well below LOAD_WIN unless a test lets the window expire on purpose. Broken sequences, sequences issued during the exit pause, and addresses with upper bits set are sent on purpose, so that ignored steps can be seen to leave the outputs unchanged.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   localparam int unsigned MATCH_W = 15;

   localparam logic [MATCH_W-1:0] LOC_HI = 15'h5555;
   localparam logic [MATCH_W-1:0] LOC_LO = 15'h2AAA;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;

   // third-step opcodes
   localparam logic [7:0] OP_ARM     = 8'hA0;
   localparam logic [7:0] OP_ID_IN3  = 8'h90;
   localparam logic [7:0] OP_ID_OUT  = 8'hF0;
   localparam logic [7:0] OP_EXTEND  = 8'h80;

   // sixth-step opcodes
   localparam logic [7:0] OP_WIPE    = 8'h10;
   localparam logic [7:0] OP_UNPROT  = 8'h20;
   localparam logic [7:0] OP_ID_IN6  = 8'h60;

   localparam logic [7:0] CODE_MAKER = 8'hBF;
   localparam logic [7:0] CODE_DEV_A = 8'h07;
   localparam logic [7:0] CODE_DEV_B = 8'h08;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_K1,
      ST_K2,
      ST_X3,
      ST_X4,
      ST_X5,
      ST_LOAD,
      ST_PAUSE
   } seq_state_e;

endpackage

// File: rtl/cmdseq_classify.sv
module cmdseq_classify
   import cmdseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              at_hi,
   output logic              step_key1,
   output logic              step_key2
);

   logic [MATCH_W-1:0] low_addr;
   logic               at_lo;

   assign low_addr  = addr[MATCH_W-1:0];
   assign at_hi     = (low_addr == LOC_HI);
   assign at_lo     = (low_addr == LOC_LO);
   assign step_key1 = at_hi && (data == KEY_FIRST);
   assign step_key2 = at_lo && (data == KEY_SECOND);

endmodule

// File: rtl/cmdseq_counter.sv
module cmdseq_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + 1'b1;
   end

endmodule

// File: rtl/cmdseq_idmux.sv
module cmdseq_idmux
   import cmdseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEV_VARIANT = 0
) (
   input  logic              id_active,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              sel,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] dev_code;

   generate
      if (DEV_VARIANT == 0) begin : g_dev_a
         assign dev_code = CODE_DEV_A;
      end else begin : g_dev_b
         assign dev_code = CODE_DEV_B;
      end
   endgenerate

   assign sel   = id_active;
   assign rdata = !id_active ? '0 : (rd_addr[0] ? dev_code : CODE_MAKER);

endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
   import cmdseq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned PAGE_BYTES    = 128,
   parameter int unsigned LOAD_WIN      = 64,
   parameter int unsigned EXIT_PAUSE    = 2000,
   parameter int unsigned DEV_VARIANT   = 0,
   parameter bit          PROT_AT_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              id_mode,
   output logic              prot_on,
   output logic              id_rd_sel,
   output logic [DATA_W-1:0] id_rd_data,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_data,
   output logic              erase_pulse
);

   localparam int unsigned SPAN_A = (PAGE_BYTES > LOAD_WIN) ? PAGE_BYTES : LOAD_WIN;
   localparam int unsigned SPAN   = (SPAN_A > EXIT_PAUSE) ? SPAN_A : EXIT_PAUSE;
   localparam int unsigned CNT_W  = $clog2(SPAN + 1);
   localparam logic [CNT_W-1:0] LAST_BYTE  = CNT_W'(PAGE_BYTES - 1);
   localparam logic [CNT_W-1:0] LAST_QUIET = CNT_W'(LOAD_WIN - 1);
   localparam logic [CNT_W-1:0] LAST_PAUSE = CNT_W'(EXIT_PAUSE - 1);

   generate
      if (ADDR_W < MATCH_W) begin : g_chk_addr
         $error("cmdseq_decoder: ADDR_W must be at least 15");
      end
      if (DATA_W != 8) begin : g_chk_data
         $error("cmdseq_decoder: DATA_W must be 8");
      end
      if (PAGE_BYTES < 1 || LOAD_WIN < 1 || EXIT_PAUSE < 1) begin : g_chk_cnt
         $error("cmdseq_decoder: counts must be non-zero");
      end
   endgenerate

   seq_state_e        st_q, st_d;
   logic              prot_d, id_d, we_d, wipe_d;
   logic              at_hi, step_key1, step_key2;
   logic              byte_clr, byte_inc, tmr_clr, tmr_inc;
   logic [CNT_W-1:0]  byte_cnt, tmr_cnt;

   cmdseq_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_classify (
      .addr      (wr_addr),
      .data      (wr_data),
      .at_hi     (at_hi),
      .step_key1 (step_key1),
      .step_key2 (step_key2)
   );

   cmdseq_counter #(.CNT_W(CNT_W)) u_byte_cnt (
      .clk (clk), .rst_n (rst_n), .clr (byte_clr), .inc (byte_inc), .q (byte_cnt)
   );

   cmdseq_counter #(.CNT_W(CNT_W)) u_tmr_cnt (
      .clk (clk), .rst_n (rst_n), .clr (tmr_clr), .inc (tmr_inc), .q (tmr_cnt)
   );

   cmdseq_idmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_VARIANT(DEV_VARIANT)) u_idmux (
      .id_active (id_mode),
      .rd_addr   (rd_addr),
      .sel       (id_rd_sel),
      .rdata     (id_rd_data)
   );

   always_comb begin
      st_d     = st_q;
      prot_d   = prot_on;
      id_d     = id_mode;
      we_d     = 1'b0;
      wipe_d   = 1'b0;
      byte_clr = 1'b0;
      byte_inc = 1'b0;
      tmr_clr  = 1'b0;
      tmr_inc  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (wr_stb) begin
               if (step_key1)              st_d = ST_K1;
               else if (!prot_on && !id_mode) we_d = 1'b1;
            end
         end
         ST_K1: if (wr_stb) st_d = step_key2 ? ST_K2 : ST_IDLE;
         ST_K2: begin
            if (wr_stb) begin
               st_d = ST_IDLE;
               if (at_hi) begin
                  case (wr_data)
                     OP_ARM: begin
                        prot_d   = 1'b1;
                        st_d     = ST_LOAD;
                        byte_clr = 1'b1;
                        tmr_clr  = 1'b1;
                     end
                     OP_ID_IN3: id_d = 1'b1;
                     OP_ID_OUT: begin
                        st_d    = ST_PAUSE;
                        tmr_clr = 1'b1;
                     end
                     OP_EXTEND: st_d = ST_X3;
                     default:   st_d = ST_IDLE;
                  endcase
               end
            end
         end
         ST_X3: if (wr_stb) st_d = step_key1 ? ST_X4 : ST_IDLE;
         ST_X4: if (wr_stb) st_d = step_key2 ? ST_X5 : ST_IDLE;
         ST_X5: begin
            if (wr_stb) begin
               st_d = ST_IDLE;
               if (at_hi) begin
                  case (wr_data)
                     OP_WIPE:   wipe_d = 1'b1;
                     OP_UNPROT: prot_d = 1'b0;
                     OP_ID_IN6: id_d   = 1'b1;
                     default:   st_d   = ST_IDLE;
                  endcase
               end
            end
         end
         ST_LOAD: begin
            if (wr_stb) begin
               we_d    = 1'b1;
               tmr_clr = 1'b1;
               if (byte_cnt == LAST_BYTE) st_d = ST_IDLE;
               else                       byte_inc = 1'b1;
            end else if (tmr_cnt == LAST_QUIET) begin
               st_d = ST_IDLE;
            end else begin
               tmr_inc = 1'b1;
            end
         end
         ST_PAUSE: begin
            if (tmr_cnt == LAST_PAUSE) begin
               st_d = ST_IDLE;
               id_d = 1'b0;
            end else begin
               tmr_inc = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         prot_on     <= PROT_AT_RESET;
         id_mode     <= 1'b0;
         arr_we      <= 1'b0;
         erase_pulse <= 1'b0;
         arr_addr    <= '0;
         arr_data    <= '0;
      end else begin
         st_q        <= st_d;
         prot_on     <= prot_d;
         id_mode     <= id_d;
         arr_we      <= we_d;
         erase_pulse <= wipe_d;
         if (we_d) begin
            arr_addr <= wr_addr;
            arr_data <= wr_data;
         end
      end
   end

endmodule

// File: rtl/cmdseq_decoder_chk.sv
module cmdseq_decoder_chk #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              id_mode,
   input logic              prot_on,
   input logic              id_rd_sel,
   input logic [DATA_W-1:0] id_rd_data,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr,
   input logic [DATA_W-1:0] arr_data,
   input logic              erase_pulse
);

   AST_WE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> ($past(wr_stb) && arr_data == $past(wr_data) && arr_addr == $past(wr_addr))); // R2

   AST_PROT_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_on) |-> ($past(wr_stb) && $past(wr_data) == 8'hA0)); // R2

   AST_PROT_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_on) |-> ($past(wr_stb) && $past(wr_data) == 8'h20)); // R5

   AST_ERASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_pulse |-> ($past(wr_stb) && $past(wr_data) == 8'h10)); // R6

   AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_pulse |=> !erase_pulse); // R6

   AST_ID_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> ($past(wr_stb) && ($past(wr_data) == 8'h90 || $past(wr_data) == 8'h60))); // R7

   AST_ID_MAKER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (id_mode && !rd_addr[0]) |-> (id_rd_sel && id_rd_data == 8'hBF)); // R8

   AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_pulse && arr_we)); // R10

endmodule

bind cmdseq_decoder cmdseq_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_cmdseq_decoder.sv
`timescale 1ns/1ps
module test_cmdseq_decoder;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int PAGE = 4;
   localparam int WIN = 5;
   localparam int PAUSE = 6;
   localparam int VARIANT = 1;
   localparam logic [7:0] DEV_EXP = (VARIANT == 0) ? 8'h07 : 8'h08;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic id_mode, prot_on, id_rd_sel, arr_we, erase_pulse;
   logic [DW-1:0] id_rd_data, arr_data;
   logic [AW-1:0] arr_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   cmdseq_decoder #(
      .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PAGE), .LOAD_WIN(WIN),
      .EXIT_PAUSE(PAUSE), .DEV_VARIANT(VARIANT), .PROT_AT_RESET(1'b0)
   ) i_cmdseq_decoder (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .id_mode(id_mode), .prot_on(prot_on), .id_rd_sel(id_rd_sel),
      .id_rd_data(id_rd_data), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
      .erase_pulse(erase_pulse)
   );

   // behavioural reference model
   logic [22:0] hist[$];
   bit m_id, m_prot, m_we, m_er, m_load, m_pause;
   int m_bytes, m_quiet, m_pcnt;
   logic [AW-1:0] m_waddr;
   logic [DW-1:0] m_wdata;

   function automatic bit step_ok(int idx, logic [14:0] a, logic [7:0] d, logic [7:0] third);
      case (idx)
         0, 3:    return a == 15'h5555 && d == 8'hAA;
         1, 4:    return a == 15'h2AAA && d == 8'h55;
         2:       return a == 15'h5555 && (d == 8'hA0 || d == 8'h90 || d == 8'hF0 || d == 8'h80);
         5:       return third == 8'h80 && a == 15'h5555 && (d == 8'h10 || d == 8'h20 || d == 8'h60);
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         m_id = 0; m_prot = 0; m_we = 0; m_er = 0; m_load = 0; m_pause = 0;
         m_bytes = 0; m_quiet = 0; m_pcnt = 0;
      end else begin
         m_we = 0; m_er = 0;
         if (m_pause) begin
            if (m_pcnt == PAUSE - 1) begin m_pause = 0; m_id = 0; end
            else m_pcnt++;
         end else if (m_load) begin
            if (wr_stb) begin
               m_we = 1; m_waddr = wr_addr; m_wdata = wr_data;
               m_bytes++; m_quiet = 0;
               if (m_bytes == PAGE) m_load = 0;
            end else begin
               m_quiet++;
               if (m_quiet == WIN) m_load = 0;
            end
         end else if (wr_stb) begin
            logic [7:0] third;
            int n;
            hist.push_back({wr_addr[14:0], wr_data});
            n = hist.size();
            third = (n > 2) ? hist[2][7:0] : 8'h00;
            if (!step_ok(n - 1, wr_addr[14:0], wr_data, third)) begin
               if (n == 1 && !m_prot && !m_id) begin
                  m_we = 1; m_waddr = wr_addr; m_wdata = wr_data;
               end
               hist.delete();
            end else if (n == 3 && wr_data != 8'h80) begin
               if (wr_data == 8'hA0) begin m_prot = 1; m_load = 1; m_bytes = 0; m_quiet = 0; end
               else if (wr_data == 8'h90) m_id = 1;
               else begin m_pause = 1; m_pcnt = 0; end
               hist.delete();
            end else if (n == 6) begin
               if (wr_data == 8'h10) m_er = 1;
               else if (wr_data == 8'h20) m_prot = 0;
               else m_id = 1;
               hist.delete();
            end
         end
      end
   end

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("id_mode", 32'(id_mode), 32'(m_id));
         chk("prot_on", 32'(prot_on), 32'(m_prot));
         chk("arr_we", 32'(arr_we), 32'(m_we));
         chk("erase_pulse", 32'(erase_pulse), 32'(m_er));
         chk("id_rd_sel", 32'(id_rd_sel), 32'(m_id));
         chk("id_rd_data", 32'(id_rd_data),
             32'(!m_id ? 8'h00 : (rd_addr[0] ? DEV_EXP : 8'hBF)));
         if (m_we) begin
            chk("arr_addr", 32'(arr_addr), 32'(m_waddr));
            chk("arr_data", 32'(arr_data), 32'(m_wdata));
         end
      end
   end

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic gap(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock(logic [AW-1:0] off);
      wr(off | 17'h05555, 8'hAA);
      wr(off | 17'h02AAA, 8'h55);
   endtask

   task automatic six(logic [7:0] last);
      unlock(17'h0); wr(17'h05555, 8'h80);
      unlock(17'h0); wr(17'h05555, last);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      gap(3);
      #1;
      chk("reset id_mode", 32'(id_mode), 0);
      chk("reset prot_on", 32'(prot_on), 0);
      chk("reset arr_we", 32'(arr_we), 0);
      chk("reset erase_pulse", 32'(erase_pulse), 0);
      @(negedge clk); rst_n = 1'b1;
      gap(2);

      cur_req = "R4"; // unprotected plain writes pass
      wr(17'h00123, 8'h3C); wr(17'h1FFFF, 8'hC3); gap(2);

      cur_req = "R10"; // broken sequences do nothing
      wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h12); gap(2);
      unlock(17'h0); wr(17'h05555, 8'h77); gap(2);
      unlock(17'h0); wr(17'h05555, 8'h80); wr(17'h02AAA, 8'hAA); gap(2);
      wr(17'h00010, 8'h01); gap(2);

      cur_req = "R2"; // arm and load part of a page
      unlock(17'h0); wr(17'h05555, 8'hA0);
      wr(17'h00200, 8'h11); wr(17'h00201, 8'h22); wr(17'h00202, 8'h33);
      cur_req = "R3"; // quiet window expires, protected write dropped
      gap(WIN + 3);
      wr(17'h00300, 8'h44); gap(2);
      cur_req = "R4";
      wr(17'h05555, 8'h00); gap(2);

      cur_req = "R3"; // full page closes the window
      unlock(17'h0); wr(17'h05555, 8'hA0);
      for (int i = 0; i < PAGE + 2; i++) wr(17'(17'h00400 + i), 8'(8'h50 + i));
      gap(2);

      cur_req = "R11"; // upper address bits ignored in matching
      unlock(17'h18000); wr(17'h0D555, 8'h90); gap(2);
      cur_req = "R8";
      rd_addr = 17'h00000; gap(2);
      rd_addr = 17'h00001; gap(2);
      rd_addr = 17'h12346; gap(2);
      cur_req = "R12";
      wr(17'h00500, 8'h99); gap(2);
      cur_req = "R9"; // exit with pause, writes ignored meanwhile
      unlock(17'h0); wr(17'h05555, 8'hF0);
      wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
      gap(PAUSE + 3);

      cur_req = "R5"; // six-byte disable
      six(8'h20); gap(2);
      wr(17'h00600, 8'h5A); gap(2);

      cur_req = "R6"; // six-byte erase
      six(8'h10); gap(3);

      cur_req = "R7"; // six-byte identification entry
      six(8'h60);
      rd_addr = 17'h00001; gap(2);
      rd_addr = 17'h00000; gap(2);
      cur_req = "R9";
      unlock(17'h0); wr(17'h05555, 8'hF0); gap(PAUSE + 3);
      cur_req = "R4";
      wr(17'h00700, 8'hE7); gap(3);

      finish_run();
   end

endmodule